// File: doc/BRIEF.md
# Programmable Periodic Interval Timer

This block is a cyclic interval timer that counts in units of an externally supplied 250 µs tick strobe. Software loads a 7-bit period value and then issues a start command. From then on the timer wraps every (value + 1) ticks and emits a one-cycle expiry pulse on each wrap. That pulse drives an ungated frame strobe. It also sets a sticky timer-interrupt flag, but only when interrupt generation was requested at the moment the timer was started. The flag stays set until software reads the status, and the interrupt output is high while the flag is set.

Any write to the period register halts the timer, whatever value is written. Writing the command register with the start bit clear changes nothing. Writing it with the start bit set restarts the count from zero and latches the interrupt-generation request again. The top bit of the period register chooses the source of the signaling-sample strobe: either a free-running 125 µs input strobe or the timer expiry. This choice does not affect the counting.

Top module: `periodic_interval_timer`

## Requirements
- R1: After reset the timer is stopped, the period value and the sample select are 0, interrupt generation is off, and tmrIrqFlag, irqOut, frameStrobe and sampleStrobe are all 0. While the block stays in this state, ticks produce no frameStrobe.
- R2: Once started with period value v (periodWrData[6:0]), the timer advances only on tick250 cycles. frameStrobe pulses for one cycle, in the cycle after the (v+1)-th tick, and again every v+1 ticks after that.
- R3: A write to the period register (periodWrEn), with no start command in the same cycle, stops the timer. No further frameStrobe occurs until the next start.
- R4: A command write with cmdWrData[0]=1 (start) starts the timer from count 0, and restarts it from 0 if it is already running. It also latches cmdWrData[1] (interrupt generation) as the new enable.
- R5: A command write with cmdWrData[0]=0 has no effect. A stopped timer stays stopped, and a running count continues without a restart.
- R6: tmrIrqFlag is set in the cycle after a frameStrobe only if the latest start had cmdWrData[1]=1. With cmdWrData[1]=0 the flag is never set.
- R7: frameStrobe pulses on every expiry, whatever the interrupt-generation setting.
- R8: tmrIrqFlag stays set until a statusRd cycle clears it. A new expiry in the same cycle as the read wins over the clear. irqOut is high exactly while tmrIrqFlag is set.
- R9: When periodWrData[7]=1 was last written, sampleStrobe follows tick125 in the same cycle. When it is 0, sampleStrobe equals frameStrobe and tick125 is ignored.
- R10: A period write and a start command in the same cycle start the timer from 0 with the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodWrEn | input | 1 | Period register write strobe |
| periodWrData | input | 8 | Bit 7 sample select, bits 6..0 period value |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdWrData | input | 2 | Bit 0 start, bit 1 interrupt generation |
| statusRd | input | 1 | Status read strobe, clears the timer-interrupt flag |
| tick250 | input | 1 | Single-cycle 250 µs time-base strobe |
| tick125 | input | 1 | Single-cycle 125 µs time-base strobe |
| frameStrobe | output | 1 | Ungated one-cycle pulse on every expiry |
| sampleStrobe | output | 1 | Signaling-sample strobe |
| tmrIrqFlag | output | 1 | Sticky timer-interrupt status |
| irqOut | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- an expiry pulse only follows a tick;
- a halt or a start is never followed by an immediate expiry;
- the interrupt flag rises only after an expiry;
- the flag keeps its value until a status read clears it.

Other behaviours need the bench's scenarios, because they depend on the contents of the registers over many ticks. These are the exact v+1 tick spacing, the restart from zero, the no-effect command write, the re-latching of the interrupt enable, the choice of sample-strobe source and the combined write-and-start.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int START_BIT  = 0;
  localparam int IRQGEN_BIT = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // start command: count from zero
    logic halt;     // period write without start: stop
  } pitCtl_t;
endpackage

// File: rtl/pit_control.sv
module pit_control
  import pit_pkg::*;
#(
  parameter int VAL_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodWrEn,
  input  logic [VAL_W:0]   periodWrData,
  input  logic             cmdWrEn,
  input  logic [1:0]       cmdWrData,
  output pitCtl_t          ctl,
  output logic             running,
  output logic             irqEn,
  output logic [VAL_W-1:0] periodVal,
  output logic             sampleSel
);
  logic startCmd;

  assign startCmd    = cmdWrEn & cmdWrData[START_BIT];
  assign ctl.restart = startCmd;
  assign ctl.halt    = periodWrEn & ~startCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodVal <= '0;
      sampleSel <= 1'b0;
      running   <= 1'b0;
      irqEn     <= 1'b0;
    end else begin
      if (periodWrEn) begin
        periodVal <= periodWrData[VAL_W-1:0];
        sampleSel <= periodWrData[VAL_W];
      end
      if (startCmd) begin
        running <= 1'b1;
        irqEn   <= cmdWrData[IRQGEN_BIT];
      end else if (periodWrEn) begin
        running <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int VAL_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  pitCtl_t          ctl,
  input  logic             running,
  input  logic [VAL_W-1:0] periodVal,
  input  logic             tick250,
  output logic             expPulse
);
  logic [VAL_W-1:0] count;
  logic             atLimit;

  assign atLimit = (count == periodVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      expPulse <= 1'b0;
    end else begin
      expPulse <= 1'b0;
      if (ctl.restart || ctl.halt) begin
        count <= '0;
      end else if (running && tick250) begin
        if (atLimit) begin
          count    <= '0;
          expPulse <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pit_status.sv
module pit_status (
  input  logic clk,
  input  logic rstN,
  input  logic expPulse,
  input  logic irqEn,
  input  logic statusRd,
  output logic tmrIrqFlag
);
  always_ff @(posedge clk) begin
    if (!rstN)                 tmrIrqFlag <= 1'b0;
    else if (expPulse && irqEn) tmrIrqFlag <= 1'b1;
    else if (statusRd)          tmrIrqFlag <= 1'b0;
  end
endmodule

// File: rtl/periodic_interval_timer.sv
module periodic_interval_timer
  import pit_pkg::*;
#(
  parameter int VAL_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodWrEn,
  input  logic [VAL_W:0]   periodWrData,
  input  logic             cmdWrEn,
  input  logic [1:0]       cmdWrData,
  input  logic             statusRd,
  input  logic             tick250,
  input  logic             tick125,
  output logic             frameStrobe,
  output logic             sampleStrobe,
  output logic             tmrIrqFlag,
  output logic             irqOut
);
  pitCtl_t          ctl;
  logic             running;
  logic             irqEn;
  logic [VAL_W-1:0] periodVal;
  logic             sampleSel;
  logic             expPulse;

  pit_control #(.VAL_W(VAL_W)) u_control (
    .clk, .rstN, .periodWrEn, .periodWrData, .cmdWrEn, .cmdWrData,
    .ctl, .running, .irqEn, .periodVal, .sampleSel
  );

  pit_datapath #(.VAL_W(VAL_W)) u_datapath (
    .clk, .rstN, .ctl, .running, .periodVal, .tick250, .expPulse
  );

  pit_status u_status (
    .clk, .rstN, .expPulse, .irqEn, .statusRd, .tmrIrqFlag
  );

  assign frameStrobe  = expPulse;
  assign sampleStrobe = sampleSel ? tick125 : expPulse;
  assign irqOut       = tmrIrqFlag;
endmodule

// File: rtl/pit_checker.sv
module pit_checker (
  input logic       clk,
  input logic       rstN,
  input logic       periodWrEn,
  input logic       cmdWrEn,
  input logic [1:0] cmdWrData,
  input logic       statusRd,
  input logic       tick250,
  input logic       frameStrobe,
  input logic       tmrIrqFlag
);
  AST_FRAME_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |-> $past(tick250)); // R2

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (periodWrEn && !(cmdWrEn && cmdWrData[0])) |=> !frameStrobe); // R3

  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && cmdWrData[0]) |=> !frameStrobe); // R4

  AST_FLAG_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmrIrqFlag) |-> $past(frameStrobe)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (tmrIrqFlag && !statusRd) |=> tmrIrqFlag); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !frameStrobe) |=> !tmrIrqFlag); // R8
endmodule

bind periodic_interval_timer pit_checker u_pit_checker (
  .clk(clk), .rstN(rstN), .periodWrEn(periodWrEn), .cmdWrEn(cmdWrEn),
  .cmdWrData(cmdWrData), .statusRd(statusRd), .tick250(tick250),
  .frameStrobe(frameStrobe), .tmrIrqFlag(tmrIrqFlag)
);

// File: tb/test_periodic_interval_timer.sv
module test_periodic_interval_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       periodWrEn = 1'b0;
  logic [7:0] periodWrData = '0;
  logic       cmdWrEn = 1'b0;
  logic [1:0] cmdWrData = '0;
  logic       statusRd = 1'b0;
  logic       tick250 = 1'b0;
  logic       tick125 = 1'b0;
  logic       frameStrobe, sampleStrobe, tmrIrqFlag, irqOut;

  int nChecks = 0;
  int nErr = 0;
  int lastSample = 0;

  always #5 clk = ~clk;

  periodic_interval_timer i_periodic_interval_timer (
    .clk, .rstN, .periodWrEn, .periodWrData, .cmdWrEn, .cmdWrData,
    .statusRd, .tick250, .tick125, .frameStrobe, .sampleStrobe,
    .tmrIrqFlag, .irqOut
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writePeriod(input logic [7:0] v);
    @(negedge clk); periodWrEn = 1'b1; periodWrData = v;
    @(negedge clk); periodWrEn = 1'b0;
  endtask

  task automatic writeCmd(input logic [1:0] c);
    @(negedge clk); cmdWrEn = 1'b1; cmdWrData = c;
    @(negedge clk); cmdWrEn = 1'b0;
  endtask

  task automatic writeBoth(input logic [7:0] v, input logic [1:0] c);
    @(negedge clk); periodWrEn = 1'b1; periodWrData = v; cmdWrEn = 1'b1; cmdWrData = c;
    @(negedge clk); periodWrEn = 1'b0; cmdWrEn = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
  endtask

  // one tick, then a few idle cycles; returns frameStrobe seen in the cycle after it
  task automatic tickOnce(output int f);
    @(negedge clk); tick250 = 1'b1;
    @(negedge clk); tick250 = 1'b0;
    f = int'(frameStrobe);
    lastSample = int'(sampleStrobe);
    repeat (2) @(negedge clk);
  endtask

  // index of first tick followed by a frame pulse, 0 if none
  task automatic ticksToFrame(input int maxT, output int n);
    int f;
    n = 0;
    for (int i = 1; i <= maxT; i++) begin
      tickOnce(f);
      if (f != 0) begin n = i; break; end
    end
  endtask

  task automatic tReset();
    int n;
    check("R1 flag", int'(tmrIrqFlag), 0);
    check("R1 irqOut", int'(irqOut), 0);
    check("R1 frame", int'(frameStrobe), 0);
    @(negedge clk); tick125 = 1'b1; #1;
    check("R1 sample", int'(sampleStrobe), 0);
    @(negedge clk); tick125 = 1'b0;
    ticksToFrame(10, n);
    check("R1 no frame while stopped", n, 0);
  endtask

  task automatic tPeriod();
    int n;
    writePeriod(8'd3);
    writeCmd(2'b01);
    ticksToFrame(10, n);
    check("R2 first expiry tick", n, 4);
    ticksToFrame(10, n);
    check("R2 second expiry tick", n, 4);
    @(negedge clk);
    check("R6 no flag with irq generation off", int'(tmrIrqFlag), 0);
    check("R7 frame strobe with irq off seen", (n == 4) ? 1 : 0, 1);
  endtask

  task automatic tIrq();
    int n;
    writePeriod(8'd1);
    writeCmd(2'b11);
    ticksToFrame(10, n);
    check("R6 expiry tick", n, 2);
    check("R6 flag set", int'(tmrIrqFlag), 1);
    check("R8 irqOut with flag", int'(irqOut), 1);
    ticksToFrame(10, n);
    check("R8 flag sticky", int'(tmrIrqFlag), 1);
    readStatus();
    check("R8 flag cleared by read", int'(tmrIrqFlag), 0);
    check("R8 irqOut cleared", int'(irqOut), 0);
  endtask

  task automatic tRestart();
    int n, f;
    writePeriod(8'd2);
    writeCmd(2'b01);
    tickOnce(f);
    tickOnce(f);
    writeCmd(2'b01);
    ticksToFrame(10, n);
    check("R4 restart counts from zero", n, 3);
    writeCmd(2'b11);
    ticksToFrame(10, n);
    check("R4 relatched start expiry", n, 3);
    check("R4 irq enable relatched", int'(tmrIrqFlag), 1);
    readStatus();
  endtask

  task automatic tStopAndNoop();
    int n, f;
    writePeriod(8'd2);
    writeCmd(2'b01);
    tickOnce(f);
    writePeriod(8'd2);
    ticksToFrame(8, n);
    check("R3 period write stops timer", n, 0);
    writeCmd(2'b00);
    ticksToFrame(8, n);
    check("R5 start=0 leaves timer stopped", n, 0);
    writeCmd(2'b01);
    tickOnce(f);
    writeCmd(2'b10);
    ticksToFrame(8, n);
    check("R5 start=0 does not restart count", n, 2);
  endtask

  task automatic tSample();
    int n;
    writePeriod(8'h83);
    writeCmd(2'b01);
    @(negedge clk); tick125 = 1'b1; #1;
    check("R9 sel=1 follows tick125", int'(sampleStrobe), 1);
    @(negedge clk); tick125 = 1'b0; #1;
    check("R9 sel=1 low without tick125", int'(sampleStrobe), 0);
    ticksToFrame(10, n);
    check("R9 sel=1 timing unchanged", n, 4);
    check("R9 sel=1 sample not at expiry", lastSample, 0);
    writePeriod(8'h03);
    writeCmd(2'b01);
    @(negedge clk); tick125 = 1'b1; #1;
    check("R9 sel=0 ignores tick125", int'(sampleStrobe), 0);
    @(negedge clk); tick125 = 1'b0;
    ticksToFrame(10, n);
    check("R9 sel=0 sample at expiry", lastSample, 1);
  endtask

  task automatic tSameCycle();
    int n, f;
    writePeriod(8'd5);
    writeCmd(2'b01);
    tickOnce(f);
    tickOnce(f);
    writeBoth(8'd1, 2'b01);
    ticksToFrame(10, n);
    check("R10 start with new value", n, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPeriod();
    tIrq();
    tRestart();
    tStopAndNoop();
    tSample();
    tSameCycle();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++;
    nErr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule